// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block sends outgoing frames that software has laid out in memory as a ring of fragment descriptors. Each slot of the ring holds two 32-bit words: a pointer to a fragment buffer, followed by a control word that gives the fragment's byte count less one, an end-of-frame flag and an interrupt-request flag. The engine fetches the two words and reads the buffer one word at a time. It places each byte on a byte-wide transmit stream with a valid/ready handshake and marks the final byte of a frame. It then records a status word for that slot in a second array of the same length. A frame may be gathered from several consecutive fragments. Only the last of them carries the end-of-frame flag.

Software programs the two array bases, the ring size less one and a produce index, and it watches a consume index that the hardware moves forward. Memory is reached through a single 32-bit word request port. A request stays asserted, with stable address and data, until the memory raises ready for one cycle. The controller has six states. IDLE leaves for PTR when produce differs from consume. PTR reads the buffer pointer and moves to CTRL on ready. CTRL reads the control word and moves to WORD on ready. WORD reads the aligned buffer word and moves to SEND on ready. SEND emits one byte per accepted handshake. It goes back to WORD after the top byte lane of a word, goes to STAT after the last byte of the fragment, and otherwise stays. STAT writes the status word and returns to IDLE on ready, which advances the consume index.

Top module: `txdesc_dma`

## Requirements
- R1: After reset every register reads zero, and irq, tx_valid and mem_req are low.
- R2: The register map is: 0 descriptor base, 1 status base, 2 ring size less one, 3 produce index, 4 consume index (read-only), 5 interrupt status (writing 1 clears a bit), 6 interrupt enable. The two bases always read with bits [1:0] zero.
- R3: Slot i's buffer pointer is read from descriptor base + 8*i and its control word from descriptor base + 8*i + 4. Every memory address issued is word aligned.
- R4: Control bits [10:0] hold the fragment length less one. The engine sends exactly that many plus one bytes. They start at the byte address in the pointer, which may be unaligned, and the byte at address A comes from bits [8*A[1:0]+7 : 8*A[1:0]] of its word.
- R5: tx_last is high only on the final byte of a fragment whose control bit 30 (end of frame) is set.
- R6: After a fragment, the word {1, end-of-frame flag, 19 zero bits, length field} is written to status base + 4*i.
- R7: The consume index advances by one after each status write and wraps to 0 after it reaches the ring-size register. The engine issues no memory request while produce equals consume.
- R8: Interrupt status bit 0 sets after a slot whose control bit 31 is set. Bit 1 sets when the consume index catches up with produce. Both stay set until written with 1.
- R9: Interrupt enable bits only gate which status bits drive irq. Writing the enable register never changes interrupt status.
- R10: A memory request holds its address and write flag until ready, and a presented byte holds its value until tx_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory completes the request |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every buffer start offset against a range of fragment lengths. A lane-select or word-refetch error would show up as bytes shifted, repeated or skipped at word boundaries, and an off-by-one in the length field would send one byte too many or too few. The sweep runs the ring through several wraps, so a consume index that wrapped early or late would stall the run or make the engine read a stale slot. A three-fragment frame checks that tx_last stays low on the earlier fragments. The interrupt checks confirm that status bits latch while their enable is off and that changing the enable leaves the status untouched.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR,
        ST_CTRL,
        ST_WORD,
        ST_SEND,
        ST_STAT
    } txdma_state_e;

    localparam logic [2:0] REG_DBASE = 3'd0;
    localparam logic [2:0] REG_SBASE = 3'd1;
    localparam logic [2:0] REG_RLAST = 3'd2;
    localparam logic [2:0] REG_PROD  = 3'd3;
    localparam logic [2:0] REG_CONS  = 3'd4;
    localparam logic [2:0] REG_ISTAT = 3'd5;
    localparam logic [2:0] REG_IEN   = 3'd6;

    localparam int CTL_IRQ_BIT  = 31;
    localparam int CTL_LAST_BIT = 30;
endpackage

// File: rtl/txdma_lane.sv
module txdma_lane (
    input  logic [31:0] word,
    input  logic [1:0]  ofs,
    output logic [7:0]  lane
);
    always_comb begin
        lane = word[8*ofs +: 8];
    end
endmodule

// File: rtl/txdma_regs.sv
module txdma_regs
    import txdma_pkg::*;
#(
    parameter int IDXW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [2:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            done,
    input  logic            done_irq,
    output logic [31:0]     desc_base,
    output logic [31:0]     stat_base,
    output logic [IDXW-1:0] produce,
    output logic [IDXW-1:0] consume,
    output logic            irq
);
    localparam int PADW = 32 - IDXW;

    logic [IDXW-1:0] ring_last;
    logic [1:0]      int_status;
    logic [1:0]      int_en;
    logic [IDXW-1:0] cons_next;
    logic [1:0]      set_bits;
    logic [1:0]      clr_bits;

    always_comb begin
        cons_next = (consume == ring_last) ? '0 : consume + 1'b1;
        set_bits  = {done && (cons_next == produce), done && done_irq};
        clr_bits  = (reg_wr && reg_addr == REG_ISTAT) ? reg_wdata[1:0] : 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_base  <= '0;
            stat_base  <= '0;
            ring_last  <= '0;
            produce    <= '0;
            consume    <= '0;
            int_status <= '0;
            int_en     <= '0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    REG_DBASE: desc_base <= {reg_wdata[31:2], 2'b00};
                    REG_SBASE: stat_base <= {reg_wdata[31:2], 2'b00};
                    REG_RLAST: ring_last <= reg_wdata[IDXW-1:0];
                    REG_PROD:  produce   <= reg_wdata[IDXW-1:0];
                    REG_IEN:   int_en    <= reg_wdata[1:0];
                    default:   ;
                endcase
            end
            if (done) begin
                consume <= cons_next;
            end
            int_status <= (int_status & ~clr_bits) | set_bits;
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_DBASE: reg_rdata = desc_base;
            REG_SBASE: reg_rdata = stat_base;
            REG_RLAST: reg_rdata = {{PADW{1'b0}}, ring_last};
            REG_PROD:  reg_rdata = {{PADW{1'b0}}, produce};
            REG_CONS:  reg_rdata = {{PADW{1'b0}}, consume};
            REG_ISTAT: reg_rdata = {30'd0, int_status};
            REG_IEN:   reg_rdata = {30'd0, int_en};
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = |(int_status & int_en);

    // R9: enable writes leave the status register alone
    p_enable_keeps_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_IEN && !done) |=> int_status == $past(int_status));

    // R7: a finished slot moves the consume index
    p_consume_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ring_last != '0) |=> consume != $past(consume));

    // R8: a pending bit survives a cycle with no clear written
    p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_status[0] && !(reg_wr && reg_addr == REG_ISTAT)) |=> int_status[0]);
endmodule

// File: rtl/txdma_fsm.sv
module txdma_fsm
    import txdma_pkg::*;
#(
    parameter int IDXW = 8,
    parameter int SZW  = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     desc_base,
    input  logic [31:0]     stat_base,
    input  logic [IDXW-1:0] produce,
    input  logic [IDXW-1:0] consume,
    output logic            mem_req,
    output logic            mem_we,
    output logic [31:0]     mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_ready,
    output logic            tx_valid,
    output logic [7:0]      tx_data,
    output logic            tx_last,
    input  logic            tx_ready,
    output logic            done,
    output logic            done_irq
);
    localparam int PAD3 = 32 - IDXW - 3;
    localparam int PAD2 = 32 - IDXW - 2;
    localparam int ZPAD = 30 - SZW;

    txdma_state_e    state, nxt;
    logic [31:0]     cur_addr;
    logic [31:0]     word_q;
    logic [SZW-1:0]  size_q;
    logic [SZW:0]    remaining;
    logic            last_f;
    logic            irq_f;
    logic [31:0]     slot_addr;
    logic [31:0]     stat_addr;
    logic [7:0]      lane_byte;

    assign slot_addr = desc_base + {{PAD3{1'b0}}, consume, 3'b000};
    assign stat_addr = stat_base + {{PAD2{1'b0}}, consume, 2'b00};

    txdma_lane u_lane (
        .word (word_q),
        .ofs  (cur_addr[1:0]),
        .lane (lane_byte)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (produce != consume) nxt = ST_PTR;
            ST_PTR:  if (mem_ready) nxt = ST_CTRL;
            ST_CTRL: if (mem_ready) nxt = ST_WORD;
            ST_WORD: if (mem_ready) nxt = ST_SEND;
            ST_SEND: begin
                if (tx_ready) begin
                    if (remaining == 1) nxt = ST_STAT;
                    else if (cur_addr[1:0] == 2'b11) nxt = ST_WORD;
                end
            end
            ST_STAT: if (mem_ready) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            word_q    <= '0;
            size_q    <= '0;
            remaining <= '0;
            last_f    <= 1'b0;
            irq_f     <= 1'b0;
        end else begin
            unique case (state)
                ST_PTR: if (mem_ready) cur_addr <= mem_rdata;
                ST_CTRL: if (mem_ready) begin
                    size_q    <= mem_rdata[SZW-1:0];
                    remaining <= {1'b0, mem_rdata[SZW-1:0]} + 1'b1;
                    last_f    <= mem_rdata[CTL_LAST_BIT];
                    irq_f     <= mem_rdata[CTL_IRQ_BIT];
                end
                ST_WORD: if (mem_ready) word_q <= mem_rdata;
                ST_SEND: if (tx_ready) begin
                    cur_addr  <= cur_addr + 1'b1;
                    remaining <= remaining - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tx_valid  = 1'b0;
        tx_last   = 1'b0;
        unique case (state)
            ST_PTR: begin
                mem_req  = 1'b1;
                mem_addr = slot_addr;
            end
            ST_CTRL: begin
                mem_req  = 1'b1;
                mem_addr = slot_addr + 32'd4;
            end
            ST_WORD: begin
                mem_req  = 1'b1;
                mem_addr = {cur_addr[31:2], 2'b00};
            end
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_last  = last_f && (remaining == 1);
            end
            ST_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = stat_addr;
                mem_wdata = {1'b1, last_f, {ZPAD{1'b0}}, size_q};
            end
            default: ;
        endcase
    end

    assign tx_data  = lane_byte;
    assign done     = (state == ST_STAT) && mem_ready;
    assign done_irq = irq_f;

    // R10: request held steady until the memory answers
    p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R10: byte held steady until the sink takes it
    p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    // R3: every address is word aligned
    p_addr_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R5: the closing byte ends the stream for this slot
    p_last_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_last && tx_ready) |=> !tx_valid);
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma #(
    parameter int IDXW = 8,
    parameter int SZW  = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        irq
);
    logic [31:0]     desc_base;
    logic [31:0]     stat_base;
    logic [IDXW-1:0] produce;
    logic [IDXW-1:0] consume;
    logic            done;
    logic            done_irq;

    txdma_regs #(.IDXW(IDXW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .done      (done),
        .done_irq  (done_irq),
        .desc_base (desc_base),
        .stat_base (stat_base),
        .produce   (produce),
        .consume   (consume),
        .irq       (irq)
    );

    txdma_fsm #(.IDXW(IDXW), .SZW(SZW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .desc_base (desc_base),
        .stat_base (stat_base),
        .produce   (produce),
        .consume   (consume),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready),
        .done      (done),
        .done_irq  (done_irq)
    );
endmodule

// File: tb/txdesc_dma_test.sv
module txdesc_dma_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        irq;

    logic [31:0] mem [0:255];
    logic [7:0]  cap_b [0:63];
    logic        cap_l [0:63];
    int          cap_n = 0;
    int          cyc = 0;
    int          wcnt = 0;
    int          reqcnt = 0;
    int          tests = 0;
    int          fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txdesc_dma uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .irq(irq)
    );

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    // sink readiness changes just after each rising edge
    always begin
        @(posedge clk);
        #1;
        tx_ready = (cyc % 5) != 2;
        cyc = cyc + 1;
    end

    // memory model and byte capture, evaluated at the falling edge
    always @(negedge clk) begin
        if (mem_req) reqcnt <= reqcnt + 1;
        if (mem_ready) begin
            mem_ready <= 1'b0;
        end else if (mem_req) begin
            if (wcnt != 0) begin
                wcnt <= wcnt - 1;
            end else begin
                mem_ready <= 1'b1;
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[9:2]];
                wcnt <= cyc % 3;
            end
        end
        if (tx_valid && tx_ready && cap_n < 64) begin
            cap_b[cap_n] <= tx_data;
            cap_l[cap_n] <= tx_last;
            cap_n <= cap_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_consume(input logic [31:0] exp);
        logic [31:0] v;
        for (int n = 0; n < 3000; n++) begin
            reg_read(3'd4, v);
            if (v == exp) break;
        end
        chk("R7 consume index", v, exp);
        repeat (2) @(negedge clk);
    endtask

    task automatic put_desc(input int slot, input logic [31:0] ptr, input logic [31:0] ctl);
        mem[(32'h44 >> 2) + 2*slot]     = ptr;
        mem[(32'h44 >> 2) + 2*slot + 1] = ctl;
    endtask

    initial begin
        logic [31:0] v;
        int cons;
        int k;
        int base_req;
        for (int i = 0; i < 256; i++)
            mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
        repeat (3) @(negedge clk);
        // R1: reset state, sampled before release
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        for (int r = 0; r < 7; r++) begin
            reg_read(r[2:0], v);
            chk("R1 register zero", v, 32'd0);
        end
        // R2: map and base alignment
        reg_write(3'd0, 32'h47);
        reg_write(3'd1, 32'h103);
        reg_write(3'd2, 32'd3);
        reg_read(3'd0, v); chk("R2 desc base", v, 32'h44);
        reg_read(3'd1, v); chk("R2 status base", v, 32'h100);
        reg_read(3'd2, v); chk("R2 ring size", v, 32'd3);

        // R7: empty ring issues nothing
        base_req = reqcnt;
        repeat (20) @(negedge clk);
        chk("R7 idle no request", reqcnt - base_req, 0);

        // gathered frame: 8 + 8 + 4 bytes, last and interrupt on the third
        put_desc(0, 32'h201, 32'd7);
        put_desc(1, 32'h209, 32'd7);
        put_desc(2, 32'h211, 32'hC000_0003);
        cap_n = 0;
        reg_write(3'd3, 32'd3);
        wait_consume(32'd3);
        chk("R4 frame byte count", cap_n, 20);
        for (int i = 0; i < 20; i++) begin
            chk("R4 frame byte", {24'd0, cap_b[i]}, {24'd0, pat(32'h201 + i)});
            chk("R5 frame last flag", {31'd0, cap_l[i]}, {31'd0, i == 19});
        end
        chk("R6 status slot 0", mem[64], 32'h8000_0007);
        chk("R6 status slot 1", mem[65], 32'h8000_0007);
        chk("R6 status slot 2", mem[66], 32'hC000_0003);
        reg_read(3'd5, v); chk("R8 status set", v, 32'd3);
        chk("R9 irq masked", {31'd0, irq}, 32'd0);
        reg_write(3'd6, 32'd1);
        reg_read(3'd5, v); chk("R9 enable keeps status", v, 32'd3);
        chk("R9 irq enabled", {31'd0, irq}, 32'd1);
        reg_write(3'd5, 32'd1);
        reg_read(3'd5, v); chk("R8 w1c bit0", v, 32'd2);
        chk("R9 irq after clear", {31'd0, irq}, 32'd0);
        reg_write(3'd5, 32'd2);
        reg_read(3'd5, v); chk("R8 w1c bit1", v, 32'd0);

        // sweep offsets and lengths through several ring wraps
        cons = 3;
        for (int o = 0; o < 4; o++) begin
            for (int s = 0; s < 7; s++) begin
                k = (s == 6) ? 9 : s;
                put_desc(cons, 32'h280 + o + 16*s, 32'h4000_0000 | k);
                cap_n = 0;
                cons = (cons == 3) ? 0 : cons + 1;
                reg_write(3'd3, cons);
                wait_consume(cons);
                chk("R4 sweep byte count", cap_n, k + 1);
                for (int i = 0; i <= k; i++) begin
                    chk("R4 sweep byte", {24'd0, cap_b[i]}, {24'd0, pat(32'h280 + o + 16*s + i)});
                    chk("R5 sweep last", {31'd0, cap_l[i]}, {31'd0, i == k});
                end
                chk("R6 sweep status", mem[64 + ((cons + 3) % 4)], 32'hC000_0000 | k);
            end
        end
        reg_read(3'd5, v); chk("R8 only drained bit", v, 32'd2);
        chk("R9 bit1 masked", {31'd0, irq}, 32'd0);
        base_req = reqcnt;
        repeat (20) @(negedge clk);
        chk("R7 idle after sweep", reqcnt - base_req, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule